// File: doc/BRIEF.md
# Exception Entry and Vector Unit

This block sits next to a 32-bit in-order core and performs exception entry. Each cycle the pipeline may raise any number of fault request lines, one line per fault class, together with the context of the faulting instruction. The context is its PC, whether it sits in a branch delay slot, the bad virtual address, a load/store flag, the address-space identifier, the virtual page number and a coprocessor number. The block picks one request by fixed priority. From that request it derives the 5-bit exception code and the handler address. In a single clock edge it updates the exception-related control state: the cause code, delay-slot flag and coprocessor field, the bad-address register, the translation-miss page fields, the exception PC and the exception-level bit.

On that same edge it raises a one-cycle redirect strobe with the handler PC. The fetch unit follows that strobe. The vector-base select, the vector-base register and the interrupt vector-spacing select come in as static configuration inputs. The exception-level bit is kept inside the block. The reset request clears it.

Top module: `exc_entry_unit`

## Requirements
- R1: Request bit positions are 0 reset, 1 NMI, 2 machine check, 3 address error, 4 TLB refill, 5 TLB invalid, 6 TLB modified, 7 coprocessor unusable, 8 syscall, 9 breakpoint, 10 reserved instruction, 11 overflow, 12 trap, 13 interrupt. When several bits are set, the lowest-numbered set bit is served and the others are ignored.
- R2: The exception code is written for every class except reset and NMI. The codes are: interrupt 0, TLB modified 1, TLB refill or invalid 2 on a load and 3 on a store, address error 4 on a load and 5 on a store, syscall 8, breakpoint 9, reserved instruction 10, coprocessor unusable 11, overflow 12, trap 13, machine check 24.
- R3: For all classes other than reset and NMI, the handler PC is a base plus an offset. The base is 0xBFC00200 when the base-select input is 1, and the vector-base input when it is 0.
- R4: The offset is 0x000 for a TLB refill taken with exception level 0, and 0x180 for a refill taken with level 1. An interrupt uses 0x200 when the spacing select is 1 and 0x180 when it is 0. Every other class uses 0x180.
- R5: Reset and NMI redirect to 0xBFC00000. Reset clears the exception level and changes nothing else. NMI writes the faulting PC into the exception PC, sets the level, and leaves the cause fields unchanged.
- R6: For the other classes, when the exception level is 0 before entry, the exception PC takes the faulting PC and the delay-slot flag is cleared. When the instruction is in a delay slot, the flag is set instead and the exception PC takes the faulting PC minus 4. When the level is already 1, both are left unchanged.
- R7: Every accepted request other than reset leaves the exception level at 1 after the update edge.
- R8: Address errors and the three TLB classes load the bad virtual address. All other classes leave it unchanged.
- R9: The three TLB classes load the page-miss fields. The ASID field takes the fault ASID. The VPN2 field takes the VPN shifted right by 2, and the 2-bit extension field takes VPN bits 1:0. The context page field takes the VPN shifted right by 2.
- R10: Coprocessor unusable writes the 2-bit coprocessor number into the cause coprocessor field. Other classes leave that field unchanged.
- R11: All outputs are registered and reset to 0. A request sampled on an edge produces, on that same edge, a redirect strobe lasting one cycle together with the handler PC and all register updates. In a cycle with no request there is no strobe and no register changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fault_req | input | 14 | Fault request lines, bit positions as in R1 |
| fault_pc | input | 32 | PC of the faulting instruction |
| fault_in_delay | input | 1 | Faulting instruction is in a branch delay slot |
| fault_vaddr | input | 32 | Faulting virtual address |
| fault_store | input | 1 | 1 for a store access, 0 for a load |
| fault_asid | input | 8 | Address-space identifier of the access |
| fault_vpn | input | 21 | Virtual page number of the access |
| fault_cop | input | 2 | Coprocessor number for coprocessor unusable |
| cfg_bev | input | 1 | Vector base select (1 = boot base) |
| cfg_iv | input | 1 | Interrupt vector spacing select |
| cfg_ebase | input | 32 | Vector base used when cfg_bev is 0 |
| cause_exccode | output | 5 | Cause exception code |
| cause_bd | output | 1 | Cause delay-slot flag |
| cause_ce | output | 2 | Cause coprocessor field |
| badvaddr | output | 32 | Bad virtual address register |
| entryhi_asid | output | 8 | Page-miss ASID field |
| entryhi_vpn2 | output | 19 | Page-miss VPN2 field |
| entryhi_vpn2x | output | 2 | Page-miss VPN2 extension field |
| context_badvpn2 | output | 19 | Context bad page field |
| epc | output | 32 | Exception PC |
| status_exl | output | 1 | Exception level bit |
| redirect_valid | output | 1 | One-cycle redirect strobe |
| redirect_pc | output | 32 | Handler PC |

## Verification
Each fault class is raised alone under both base selects. This separates the base mux from the offset logic. A refill raised at level 0 and then raised again at level 1 shows that the offset follows the exception level. Nested faults raised at level 1 show that the exception PC and delay-slot flag are held, while a delay-slot fault taken at level 0 shows the minus-4 correction. Requests with several bits set show that the lower-numbered bit wins and that the context fields belonging to the losing classes are left untouched. Loads and stores of the same class separate the two codes.

// File: rtl/exc_pkg.sv
package exc_pkg;

    localparam int XLEN        = 32;
    localparam int ASID_W      = 8;
    localparam int VPN_W       = 21;
    localparam int CE_W        = 2;
    localparam int CODE_W      = 5;
    localparam int NUM_CLASSES = 14;
    localparam int CLS_W       = $clog2(NUM_CLASSES);

    typedef enum logic [CLS_W-1:0] {
        FC_RESET        = 4'd0,
        FC_NMI          = 4'd1,
        FC_MCHECK       = 4'd2,
        FC_ADDR_ERR     = 4'd3,
        FC_TLB_REFILL   = 4'd4,
        FC_TLB_INVALID  = 4'd5,
        FC_TLB_MOD      = 4'd6,
        FC_COP_UNUSABLE = 4'd7,
        FC_SYSCALL      = 4'd8,
        FC_BREAK        = 4'd9,
        FC_RESV_INSTR   = 4'd10,
        FC_OVERFLOW     = 4'd11,
        FC_TRAP         = 4'd12,
        FC_INTERRUPT    = 4'd13
    } fault_class_e;

    localparam logic [CODE_W-1:0] EC_INT    = 5'd0;
    localparam logic [CODE_W-1:0] EC_MOD    = 5'd1;
    localparam logic [CODE_W-1:0] EC_TLB_LD = 5'd2;
    localparam logic [CODE_W-1:0] EC_TLB_ST = 5'd3;
    localparam logic [CODE_W-1:0] EC_ADR_LD = 5'd4;
    localparam logic [CODE_W-1:0] EC_ADR_ST = 5'd5;
    localparam logic [CODE_W-1:0] EC_SYS    = 5'd8;
    localparam logic [CODE_W-1:0] EC_BP     = 5'd9;
    localparam logic [CODE_W-1:0] EC_RI     = 5'd10;
    localparam logic [CODE_W-1:0] EC_CPU    = 5'd11;
    localparam logic [CODE_W-1:0] EC_OV     = 5'd12;
    localparam logic [CODE_W-1:0] EC_TR     = 5'd13;
    localparam logic [CODE_W-1:0] EC_MCHK   = 5'd24;

    localparam logic [XLEN-1:0] RESET_VEC = 32'hBFC0_0000;
    localparam logic [XLEN-1:0] BOOT_BASE = 32'hBFC0_0200;
    localparam logic [XLEN-1:0] OFF_GEN   = 32'h0000_0180;
    localparam logic [XLEN-1:0] OFF_IRQ   = 32'h0000_0200;
    localparam logic [XLEN-1:0] OFF_TLBR  = 32'h0000_0000;

    // Register-update actions chosen for the winning class
    typedef struct packed {
        logic wr_code;
        logic wr_badv;
        logic wr_tlb;
        logic wr_ce;
        logic epc_cond;    // exception PC written only when level was 0
        logic epc_always;  // exception PC written regardless of level
        logic set_exl;
        logic clr_exl;
        logic fixed_vec;   // handler PC is the reset vector
    } entry_act_t;

    function automatic logic is_tlb(fault_class_e c);
        return (c == FC_TLB_REFILL) || (c == FC_TLB_INVALID) || (c == FC_TLB_MOD);
    endfunction

    function automatic logic [CODE_W-1:0] code_of(fault_class_e c, logic st);
        case (c)
            FC_MCHECK:       return EC_MCHK;
            FC_ADDR_ERR:     return st ? EC_ADR_ST : EC_ADR_LD;
            FC_TLB_REFILL,
            FC_TLB_INVALID:  return st ? EC_TLB_ST : EC_TLB_LD;
            FC_TLB_MOD:      return EC_MOD;
            FC_COP_UNUSABLE: return EC_CPU;
            FC_SYSCALL:      return EC_SYS;
            FC_BREAK:        return EC_BP;
            FC_RESV_INSTR:   return EC_RI;
            FC_OVERFLOW:     return EC_OV;
            FC_TRAP:         return EC_TR;
            default:         return EC_INT;
        endcase
    endfunction

    function automatic logic [XLEN-1:0] offset_of(fault_class_e c, logic exl, logic iv);
        case (c)
            FC_TLB_REFILL: return exl ? OFF_GEN : OFF_TLBR;
            FC_INTERRUPT:  return iv ? OFF_IRQ : OFF_GEN;
            default:       return OFF_GEN;
        endcase
    endfunction

    function automatic entry_act_t act_of(fault_class_e c);
        entry_act_t a;
        a = '0;
        case (c)
            FC_RESET: begin
                a.clr_exl   = 1'b1;
                a.fixed_vec = 1'b1;
            end
            FC_NMI: begin
                a.epc_always = 1'b1;
                a.set_exl    = 1'b1;
                a.fixed_vec  = 1'b1;
            end
            default: begin
                a.wr_code  = 1'b1;
                a.epc_cond = 1'b1;
                a.set_exl  = 1'b1;
                a.wr_badv  = (c == FC_ADDR_ERR) || is_tlb(c);
                a.wr_tlb   = is_tlb(c);
                a.wr_ce    = (c == FC_COP_UNUSABLE);
            end
        endcase
        return a;
    endfunction

endpackage

// File: rtl/exc_prio_pick.sv
module exc_prio_pick #(
    parameter int N     = 14,
    parameter int IDX_W = $clog2(N)
) (
    input  logic [N-1:0]     req,
    output logic             any,
    output logic [IDX_W-1:0] idx
);
    logic [N-1:0] lower_set;

    // lower_set[i] is true when some bit below i is requested
    assign lower_set[0] = 1'b0;
    for (genvar g = 1; g < N; g++) begin : g_chain
        assign lower_set[g] = lower_set[g-1] | req[g-1];
    end

    always_comb begin
        idx = '0;
        for (int i = 0; i < N; i++) begin
            if (req[i] && !lower_set[i]) idx = IDX_W'(i);
        end
    end

    assign any = |req;

endmodule

// File: rtl/exc_vector_calc.sv
module exc_vector_calc
    import exc_pkg::*;
#(
    parameter int ADDR_W = XLEN
) (
    input  fault_class_e        cls,
    input  logic                store,
    input  logic                exl,
    input  logic                iv,
    input  logic                bev,
    input  logic [ADDR_W-1:0]   ebase,
    output logic [CODE_W-1:0]   code,
    output logic [ADDR_W-1:0]   target,
    output entry_act_t          act
);
    logic [ADDR_W-1:0] base;
    logic [ADDR_W-1:0] off;

    always_comb begin
        act    = act_of(cls);
        code   = code_of(cls, store);
        base   = bev ? ADDR_W'(BOOT_BASE) : ebase;
        off    = ADDR_W'(offset_of(cls, exl, iv));
        target = act.fixed_vec ? ADDR_W'(RESET_VEC) : base + off;
    end

endmodule

// File: rtl/exc_cp0_regs.sv
module exc_cp0_regs
    import exc_pkg::*;
#(
    parameter int ADDR_W  = XLEN,
    parameter int ASID_WD = ASID_W,
    parameter int VPN_WD  = VPN_W,
    parameter int CE_WD   = CE_W,
    localparam int VPN2_W = VPN_WD - 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                take,
    input  entry_act_t          act,
    input  logic [CODE_W-1:0]   code,
    input  logic [ADDR_W-1:0]   target,
    input  logic [ADDR_W-1:0]   pc,
    input  logic                in_delay,
    input  logic [ADDR_W-1:0]   vaddr,
    input  logic [ASID_WD-1:0]  asid,
    input  logic [VPN_WD-1:0]   vpn,
    input  logic [CE_WD-1:0]    cop,
    output logic [CODE_W-1:0]   exccode_q,
    output logic                bd_q,
    output logic [CE_WD-1:0]    ce_q,
    output logic [ADDR_W-1:0]   badv_q,
    output logic [ASID_WD-1:0]  asid_q,
    output logic [VPN2_W-1:0]   vpn2_q,
    output logic [1:0]          vpn2x_q,
    output logic [VPN2_W-1:0]   ctx_vpn2_q,
    output logic [ADDR_W-1:0]   epc_q,
    output logic                exl_q,
    output logic                redir_q,
    output logic [ADDR_W-1:0]   redir_pc_q
);
    logic epc_we;

    assign epc_we = take && (act.epc_always || (act.epc_cond && !exl_q));

    always_ff @(posedge clk) begin
        if (rst) begin
            exccode_q  <= '0;
            bd_q       <= 1'b0;
            ce_q       <= '0;
            badv_q     <= '0;
            asid_q     <= '0;
            vpn2_q     <= '0;
            vpn2x_q    <= '0;
            ctx_vpn2_q <= '0;
            epc_q      <= '0;
            exl_q      <= 1'b0;
            redir_q    <= 1'b0;
            redir_pc_q <= '0;
        end else begin
            redir_q <= take;
            if (take) begin
                redir_pc_q <= target;
                if (act.wr_code) exccode_q <= code;
                if (act.wr_ce)   ce_q      <= cop;
                if (act.wr_badv) badv_q    <= vaddr;
                if (act.wr_tlb) begin
                    asid_q     <= asid;
                    vpn2_q     <= vpn[VPN_WD-1:2];
                    vpn2x_q    <= vpn[1:0];
                    ctx_vpn2_q <= vpn[VPN_WD-1:2];
                end
                if (act.set_exl)      exl_q <= 1'b1;
                else if (act.clr_exl) exl_q <= 1'b0;
            end
            if (epc_we) begin
                if (act.epc_cond) begin
                    bd_q  <= in_delay;
                    epc_q <= in_delay ? pc - ADDR_W'(4) : pc;
                end else begin
                    epc_q <= pc;
                end
            end
        end
    end

endmodule

// File: rtl/exc_entry_unit.sv
module exc_entry_unit
    import exc_pkg::*;
#(
    parameter int ADDR_W  = XLEN,
    parameter int ASID_WD = ASID_W,
    parameter int VPN_WD  = VPN_W,
    parameter int CE_WD   = CE_W,
    localparam int VPN2_W = VPN_WD - 2
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [NUM_CLASSES-1:0] fault_req,
    input  logic [ADDR_W-1:0]      fault_pc,
    input  logic                   fault_in_delay,
    input  logic [ADDR_W-1:0]      fault_vaddr,
    input  logic                   fault_store,
    input  logic [ASID_WD-1:0]     fault_asid,
    input  logic [VPN_WD-1:0]      fault_vpn,
    input  logic [CE_WD-1:0]       fault_cop,
    input  logic                   cfg_bev,
    input  logic                   cfg_iv,
    input  logic [ADDR_W-1:0]      cfg_ebase,
    output logic [CODE_W-1:0]      cause_exccode,
    output logic                   cause_bd,
    output logic [CE_WD-1:0]       cause_ce,
    output logic [ADDR_W-1:0]      badvaddr,
    output logic [ASID_WD-1:0]     entryhi_asid,
    output logic [VPN2_W-1:0]      entryhi_vpn2,
    output logic [1:0]             entryhi_vpn2x,
    output logic [VPN2_W-1:0]      context_badvpn2,
    output logic [ADDR_W-1:0]      epc,
    output logic                   status_exl,
    output logic                   redirect_valid,
    output logic [ADDR_W-1:0]      redirect_pc
);
    logic              any_req;
    logic [CLS_W-1:0]  win_idx;
    fault_class_e      win_cls;
    logic [CODE_W-1:0] win_code;
    logic [ADDR_W-1:0] win_target;
    entry_act_t        win_act;

    exc_prio_pick #(.N(NUM_CLASSES), .IDX_W(CLS_W)) u_pick (
        .req (fault_req),
        .any (any_req),
        .idx (win_idx)
    );

    assign win_cls = fault_class_e'(win_idx);

    exc_vector_calc #(.ADDR_W(ADDR_W)) u_vec (
        .cls    (win_cls),
        .store  (fault_store),
        .exl    (status_exl),
        .iv     (cfg_iv),
        .bev    (cfg_bev),
        .ebase  (cfg_ebase),
        .code   (win_code),
        .target (win_target),
        .act    (win_act)
    );

    exc_cp0_regs #(
        .ADDR_W (ADDR_W),
        .ASID_WD(ASID_WD),
        .VPN_WD (VPN_WD),
        .CE_WD  (CE_WD)
    ) u_regs (
        .clk        (clk),
        .rst        (rst),
        .take       (any_req),
        .act        (win_act),
        .code       (win_code),
        .target     (win_target),
        .pc         (fault_pc),
        .in_delay   (fault_in_delay),
        .vaddr      (fault_vaddr),
        .asid       (fault_asid),
        .vpn        (fault_vpn),
        .cop        (fault_cop),
        .exccode_q  (cause_exccode),
        .bd_q       (cause_bd),
        .ce_q       (cause_ce),
        .badv_q     (badvaddr),
        .asid_q     (entryhi_asid),
        .vpn2_q     (entryhi_vpn2),
        .vpn2x_q    (entryhi_vpn2x),
        .ctx_vpn2_q (context_badvpn2),
        .epc_q      (epc),
        .exl_q      (status_exl),
        .redir_q    (redirect_valid),
        .redir_pc_q (redirect_pc)
    );

endmodule

// File: rtl/exc_entry_checker.sv
module exc_entry_checker
    import exc_pkg::*;
#(
    parameter int ADDR_W = XLEN
) (
    input logic                   clk,
    input logic                   rst,
    input logic [NUM_CLASSES-1:0] fault_req,
    input logic [ADDR_W-1:0]      fault_vaddr,
    input logic [CODE_W-1:0]      cause_exccode,
    input logic                   cause_bd,
    input logic [ADDR_W-1:0]      badvaddr,
    input logic [ADDR_W-1:0]      epc,
    input logic                   status_exl,
    input logic                   redirect_valid,
    input logic [ADDR_W-1:0]      redirect_pc
);
    AST_REDIRECT_AFTER_REQ: assert property (@(posedge clk) disable iff (rst)
        (|fault_req) |=> redirect_valid); // R11

    AST_IDLE_NO_REDIRECT: assert property (@(posedge clk) disable iff (rst)
        !(|fault_req) |=> !redirect_valid); // R11

    AST_IDLE_HOLDS_STATE: assert property (@(posedge clk) disable iff (rst)
        !(|fault_req) |=> ($stable(epc) && $stable(badvaddr) && $stable(status_exl)
                           && $stable(cause_exccode))); // R11

    AST_RESET_REQ_VECTOR: assert property (@(posedge clk) disable iff (rst)
        fault_req[0] |=> (redirect_pc == ADDR_W'(RESET_VEC) && !status_exl)); // R5

    AST_EXL_SET_ON_ENTRY: assert property (@(posedge clk) disable iff (rst)
        ((|fault_req) && !fault_req[0]) |=> status_exl); // R7

    AST_NESTED_HOLDS_EPC: assert property (@(posedge clk) disable iff (rst)
        ((|fault_req[NUM_CLASSES-1:2]) && fault_req[1:0] == 2'b00 && status_exl)
        |=> ($stable(epc) && $stable(cause_bd))); // R6

    AST_ADDR_ERR_BADV: assert property (@(posedge clk) disable iff (rst)
        (fault_req[3:0] == 4'b1000) |=> (badvaddr == $past(fault_vaddr))); // R8

    AST_TLB_MOD_CODE: assert property (@(posedge clk) disable iff (rst)
        (fault_req[6:0] == 7'b1000000) |=> (cause_exccode == EC_MOD)); // R2

endmodule

bind exc_entry_unit exc_entry_checker #(.ADDR_W(ADDR_W)) u_exc_entry_checker (.*);

// File: tb/exc_entry_unit_bench.sv
module exc_entry_unit_bench;

    logic        clk = 1'b0;
    logic        rst;
    logic [13:0] fault_req;
    logic [31:0] fault_pc;
    logic        fault_in_delay;
    logic [31:0] fault_vaddr;
    logic        fault_store;
    logic [7:0]  fault_asid;
    logic [20:0] fault_vpn;
    logic [1:0]  fault_cop;
    logic        cfg_bev;
    logic        cfg_iv;
    logic [31:0] cfg_ebase;
    logic [4:0]  cause_exccode;
    logic        cause_bd;
    logic [1:0]  cause_ce;
    logic [31:0] badvaddr;
    logic [7:0]  entryhi_asid;
    logic [18:0] entryhi_vpn2;
    logic [1:0]  entryhi_vpn2x;
    logic [18:0] context_badvpn2;
    logic [31:0] epc;
    logic        status_exl;
    logic        redirect_valid;
    logic [31:0] redirect_pc;

    always #10 clk = ~clk;

    exc_entry_unit u_exc_entry_unit (.*);

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    // Reference state, written from the requirements
    logic [4:0]  m_code;
    logic        m_bd;
    logic [1:0]  m_ce;
    logic [31:0] m_badv;
    logic [7:0]  m_asid;
    logic [18:0] m_vpn2;
    logic [1:0]  m_vpn2x;
    logic [18:0] m_ctx;
    logic [31:0] m_epc;
    logic        m_exl;
    logic        m_rv;
    logic [31:0] m_rpc;

    function automatic logic [4:0] ref_code(int w, logic st);
        case (w)
            2: return 5'd24;
            3: return st ? 5'd5 : 5'd4;
            4, 5: return st ? 5'd3 : 5'd2;
            6: return 5'd1;
            7: return 5'd11;
            8: return 5'd8;
            9: return 5'd9;
            10: return 5'd10;
            11: return 5'd12;
            12: return 5'd13;
            default: return 5'd0;
        endcase
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_code = 0; m_bd = 0; m_ce = 0; m_badv = 0; m_asid = 0; m_vpn2 = 0;
            m_vpn2x = 0; m_ctx = 0; m_epc = 0; m_exl = 0; m_rv = 0; m_rpc = 0;
        end else begin
            int w;
            logic [31:0] base;
            logic [31:0] off;
            w = -1;
            for (int i = 0; i < 14; i++) begin
                if (fault_req[i] && w < 0) w = i;
            end
            m_rv = (w >= 0);
            if (w == 0) begin
                m_rpc = 32'hBFC0_0000;
                m_exl = 0;
            end else if (w == 1) begin
                m_rpc = 32'hBFC0_0000;
                m_epc = fault_pc;
                m_exl = 1;
            end else if (w > 1) begin
                base = cfg_bev ? 32'hBFC0_0200 : cfg_ebase;
                off  = 32'h180;
                if (w == 4 && !m_exl) off = 32'h0;
                if (w == 13 && cfg_iv) off = 32'h200;
                m_rpc  = base + off;
                m_code = ref_code(w, fault_store);
                if (!m_exl) begin
                    m_bd  = fault_in_delay;
                    m_epc = fault_in_delay ? fault_pc - 4 : fault_pc;
                end
                if (w >= 3 && w <= 6) m_badv = fault_vaddr;
                if (w >= 4 && w <= 6) begin
                    m_asid  = fault_asid;
                    m_vpn2  = fault_vpn[20:2];
                    m_vpn2x = fault_vpn[1:0];
                    m_ctx   = fault_vpn[20:2];
                end
                if (w == 7) m_ce = fault_cop;
                m_exl = 1;
            end
        end
    end

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (!finished) begin
            chk("R11 redirect_valid", 32'(redirect_valid), 32'(m_rv));
            chk("R3 R4 R5 redirect_pc", redirect_pc, m_rpc);
            chk("R2 exccode", 32'(cause_exccode), 32'(m_code));
            chk("R6 cause_bd", 32'(cause_bd), 32'(m_bd));
            chk("R10 cause_ce", 32'(cause_ce), 32'(m_ce));
            chk("R8 badvaddr", badvaddr, m_badv);
            chk("R9 entryhi_asid", 32'(entryhi_asid), 32'(m_asid));
            chk("R9 entryhi_vpn2", 32'(entryhi_vpn2), 32'(m_vpn2));
            chk("R9 entryhi_vpn2x", 32'(entryhi_vpn2x), 32'(m_vpn2x));
            chk("R9 context_badvpn2", 32'(context_badvpn2), 32'(m_ctx));
            chk("R5 R6 epc", epc, m_epc);
            chk("R7 status_exl", 32'(status_exl), 32'(m_exl));
        end
    end

    // One request cycle followed by one idle cycle
    task automatic fire(logic [13:0] r);
        fault_req = r;
        @(negedge clk);
        fault_req = '0;
        @(negedge clk);
    endtask

    task automatic ctx(logic [31:0] pc, logic dly, logic [31:0] va, logic st);
        fault_pc = pc; fault_in_delay = dly; fault_vaddr = va; fault_store = st;
        fault_asid = va[7:0] ^ 8'h5A; fault_vpn = va[31:11]; fault_cop = va[3:2];
    endtask

    initial begin
        #(20 * 5000);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog expired");
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        rst = 1; fault_req = '0;
        cfg_bev = 0; cfg_iv = 0; cfg_ebase = 32'h8000_0000;
        ctx(32'h0040_0100, 0, 32'h1234_5678, 0);
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);

        // R2 R3 R6 R7: syscall from level 0, then nested breakpoint (R6 hold)
        fire(14'h0100);
        ctx(32'h0040_0200, 1, 32'h2222_0000, 0);
        fire(14'h0200);
        fire(14'h0001);                       // R5 reset clears level

        // R9 R4: refill store at level 0 under boot base, then again at level 1
        cfg_bev = 1;
        ctx(32'h0040_0300, 0, 32'hDEAD_B000, 1);
        fire(14'h0010);
        ctx(32'h0040_0304, 0, 32'h7654_3210, 0);
        fire(14'h0010);
        fire(14'h0001);

        // R4: interrupt with both spacing selects
        cfg_bev = 0; cfg_ebase = 32'h8001_0000; cfg_iv = 1;
        fire(14'h2000);
        fire(14'h0001);
        cfg_iv = 0;
        fire(14'h2000);
        fire(14'h0001);

        // R6 R8: address error store and load in a delay slot
        ctx(32'h0040_0400, 1, 32'h0000_1003, 1);
        fire(14'h0008);
        fire(14'h0001);
        ctx(32'h0040_0408, 1, 32'h0000_2001, 0);
        fire(14'h0008);
        fire(14'h0001);

        // R1: all lines at once -> reset wins; machine check beats address error
        ctx(32'h0040_0500, 0, 32'hCAFE_0000, 1);
        fire(14'h3FFF);
        fire(14'h000C);
        fire(14'h0001);
        // R1 R9: TLB invalid beats interrupt and coprocessor unusable
        ctx(32'h0040_0600, 0, 32'hABCD_E004, 0);
        fire(14'h20A0);
        fire(14'h0001);
        // R10: coprocessor unusable with coprocessor 2 (vaddr bits 3:2)
        ctx(32'h0040_0700, 0, 32'h0000_0008, 0);
        fire(14'h0080);
        fire(14'h0001);
        // R2 R8: TLB modified, then overflow, trap, reserved instruction
        ctx(32'h0040_0800, 0, 32'h5555_A000, 1);
        fire(14'h0040);
        fire(14'h0001);
        fire(14'h0800);
        fire(14'h0001);
        fire(14'h1000);
        fire(14'h0001);
        fire(14'h0400);
        fire(14'h0001);
        // R5: NMI writes the exception PC even at level 1
        fire(14'h0004);
        ctx(32'h0040_0900, 1, 32'h0, 0);
        fire(14'h0002);
        // R1: NMI beats machine check
        fire(14'h0006);
        // R11: idle cycles hold state
        repeat (4) @(negedge clk);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule